// File: doc/BRIEF.md
# PWM Counting Time Base

This block is the period generator behind a PWM unit. A 15-bit counter advances on ticks from a selectable prescaler. It handles the end of each period in one of four ways, chosen by a 2-bit mode field. It can wrap to zero and keep running. It can run once and then switch itself off. It can turn round at the period and count back down to zero, giving the triangle shape used for center-aligned PWM. A fourth variant of the triangle mode raises events at both turning points.

The counter value leaves the block on a 16-bit bus whose top bit shows the current counting direction. Period events pass through a postscaler and come out as a one-cycle interrupt pulse. Register-style inputs set the mode, the period, the two divider selects and the enable. Separate write strobes let software load the counter and the period directly. A period of zero freezes the timer. While the timer is frozen that way and still enabled, it refuses new period values.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `count_o` is 0, `en_o` is 0 and `irq_o` is 0. `count_o[14:0]` holds the counter value and `count_o[15]` is the direction flag (0 = up, 1 = down).
- R2: While enabled, the counter advances once every 1, 4, 16 or 64 clocks for `prescale_i` = 0, 1, 2 or 3. The first advance is seen 1, 4, 16 or 64 clocks after the enable is written.
- R3: Mode 0 (free-running): the counter steps up by one per tick. On the tick where it equals the period, it returns to 0 and produces an interrupt event.
- R4: Mode 1 (single-shot): the counter steps up. On the tick where it equals the period, it returns to 0, the enable clears by itself, and exactly one interrupt pulse follows. `postscale_i` has no effect in this mode.
- R5: Mode 2 (up/down): on the tick where the counter equals the period while counting up, it steps to period-1 and the flag reads down. On the tick where it is 0 while counting down, it steps to 1, the flag reads up and an interrupt event is produced.
- R6: Mode 3 (up/down, both): the counter behaves as in mode 2, and the turn at the period also produces an interrupt event.
- R7: Interrupt events in modes 0, 2 and 3 are divided by `postscale_i`+1. The divider count restarts whenever the timer is disabled.
- R8: While disabled, the counter keeps its value and no interrupt pulse appears.
- R9: With a period of 0 the counter does not move and no interrupt is produced.
- R10: A period write is ignored while the timer is enabled and the period is 0. Once the timer is disabled, the same write takes effect.
- R11: A counter write loads `cnt_wdata_i` at the next clock, takes priority over a tick in the same cycle, and sets the direction to up.
- R12: `irq_o` is a registered pulse. Each postscaled event makes it high for one cycle, in the same cycle that `count_o` shows the count produced by the event's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | End-of-period mode: 0 free, 1 single-shot, 2 up/down, 3 up/down with both events |
| prescale_i | input | 2 | Tick divider select: divide by 4 to the power of the value |
| postscale_i | input | 4 | Interrupt divider: divide by value + 1 |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Enable value to write |
| per_wr_i | input | 1 | Write strobe for the period |
| per_wdata_i | input | 15 | Period value to write |
| cnt_wr_i | input | 1 | Write strobe for the counter |
| cnt_wdata_i | input | 15 | Counter value to write |
| count_o | output | 16 | Direction flag in bit 15, counter in bits 14:0 |
| en_o | output | 1 | Current enable state |
| irq_o | output | 1 | Postscaled interrupt pulse |

## Verification
The embedded properties check on every cycle the rules that hold one step at a time. A zero period or a disabled timer leaves the count unchanged. A free-running match returns the count to zero, and an up-count match turns the direction down. A single-shot match clears the enable and fires the pulse. A locked zero period stays zero. Prescaler ticks are never back to back for dividers above one. Whole sequences can only be shown by the directed scenarios. These are the triangle waveform and where its events fall in the two up/down modes, the count of pulses the postscaler lets through, each prescaler ratio, and the release of the period lock after a disable.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'b00,
        MODE_ONESHOT   = 2'b01,
        MODE_UPDN      = 2'b10,
        MODE_UPDN_BOTH = 2'b11
    } tb_mode_e;

endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = 2 * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] lim;

    always_comb begin
        span   = (DIV_W+1)'(1) << (2 * sel_i);
        lim    = DIV_W'(span - 1'b1);
        tick_o = run_i && (st_q.pre == lim);
        st_d   = st_q;
        if (!run_i || tick_o) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: with a divider above one, a tick is never followed by another tick
    assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && sel_i != '0) |=> (sel_i == '0 || !tick_o));

endmodule

// File: rtl/pwmtb_count.sv
module pwmtb_count
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  tb_mode_e         mode_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             ev_o,
    output logic             halt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic at_per, at_zero, live;

    always_comb begin
        st_d    = st_q;
        ev_o    = 1'b0;
        halt_o  = 1'b0;
        at_per  = (st_q.cnt == per_i);
        at_zero = (st_q.cnt == '0);
        live    = tick_i && (per_i != '0);
        if (!mode_i[1]) st_d.down = 1'b0;
        if (wr_i) begin
            st_d.cnt  = wdata_i;
            st_d.down = 1'b0;
        end else if (live) begin
            case (mode_i)
                MODE_FREE, MODE_ONESHOT: begin
                    if (at_per) begin
                        st_d.cnt = '0;
                        ev_o     = 1'b1;
                        halt_o   = (mode_i == MODE_ONESHOT);
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (!st_q.down) begin
                        if (at_per) begin
                            st_d.down = 1'b1;
                            st_d.cnt  = st_q.cnt - 1'b1;
                            ev_o      = (mode_i == MODE_UPDN_BOTH);
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (at_zero) begin
                            st_d.down = 1'b0;
                            st_d.cnt  = st_q.cnt + 1'b1;
                            ev_o      = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign down_o = st_q.down;

    // R9: zero period freezes the counter
    assert_zero_period_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_i == '0 && !wr_i) |=> $stable(cnt_o));

    // R8: no movement while disabled
    assert_hold_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !wr_i) |=> $stable(cnt_o));

    // R3: free-running match returns to zero
    assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && per_i != '0 && !wr_i && mode_i == MODE_FREE && at_per) |=> (cnt_o == '0));

    // R5: up-count match turns the direction down
    assert_turn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && per_i != '0 && !wr_i && mode_i[1] && !down_o && at_per) |=> down_o);

endmodule

// File: rtl/pwmtb_postscale.sv
module pwmtb_postscale #(
    parameter int SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             bypass_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ev_i,
    output logic             irq_o
);
    typedef struct packed {
        logic [SEL_W-1:0] cnt;
        logic             irq;
    } post_st_t;

    post_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (ev_i) begin
            if (bypass_i || st_q.cnt >= sel_i) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R4: in single-shot every event becomes a pulse
    assert_oneshot_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && bypass_i && ev_i) |=> irq_o);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmtb_pkg::*;
#(
    parameter int CNT_W      = 15,
    parameter int PRE_SEL_W  = 2,
    parameter int POST_SEL_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [1:0]            mode_i,
    input  logic [PRE_SEL_W-1:0]  prescale_i,
    input  logic [POST_SEL_W-1:0] postscale_i,
    input  logic                  en_wr_i,
    input  logic                  en_wdata_i,
    input  logic                  per_wr_i,
    input  logic [CNT_W-1:0]      per_wdata_i,
    input  logic                  cnt_wr_i,
    input  logic [CNT_W-1:0]      cnt_wdata_i,
    output logic [CNT_W:0]        count_o,
    output logic                  en_o,
    output logic                  irq_o
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] per;
    } top_st_t;

    top_st_t st_d, st_q;
    tb_mode_e mode;
    logic tick, ev, halt, down;
    logic [CNT_W-1:0] cnt;

    assign mode = tb_mode_e'(mode_i);

    pwmtb_prescale #(.SEL_W(PRE_SEL_W)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (st_q.en),
        .sel_i (prescale_i),
        .tick_o(tick)
    );

    pwmtb_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.en),
        .tick_i (tick),
        .mode_i (mode),
        .per_i  (st_q.per),
        .wr_i   (cnt_wr_i),
        .wdata_i(cnt_wdata_i),
        .cnt_o  (cnt),
        .down_o (down),
        .ev_o   (ev),
        .halt_o (halt)
    );

    pwmtb_postscale #(.SEL_W(POST_SEL_W)) u_post (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.en),
        .bypass_i(mode == MODE_ONESHOT),
        .sel_i   (postscale_i),
        .ev_i    (ev),
        .irq_o   (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (en_wr_i)   st_d.en = en_wdata_i;
        else if (halt) st_d.en = 1'b0;
        if (per_wr_i && !(st_q.en && st_q.per == '0)) st_d.per = per_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = {down, cnt};
    assign en_o    = st_q.en;

    // R4: single-shot match clears the enable unless software writes it
    assert_oneshot_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && mode == MODE_ONESHOT && ev && !en_wr_i) |=> !en_o);

    // R10: an enabled zero period cannot be replaced
    assert_period_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && st_q.per == '0) |=> (st_q.per == '0));

endmodule

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  pre = '0;
    logic [3:0]  post = '0;
    logic        en_wr = 1'b0, en_wd = 1'b0;
    logic        per_wr = 1'b0;
    logic [14:0] per_wd = '0;
    logic        cnt_wr = 1'b0;
    logic [14:0] cnt_wd = '0;
    logic [15:0] count;
    logic        en, irq;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    pwm_timebase dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .prescale_i(pre),
        .postscale_i(post), .en_wr_i(en_wr), .en_wdata_i(en_wd),
        .per_wr_i(per_wr), .per_wdata_i(per_wd), .cnt_wr_i(cnt_wr),
        .cnt_wdata_i(cnt_wd), .count_o(count), .en_o(en), .irq_o(irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(int m, int per, int ps, int qs);
        en_wr = 1'b1; en_wd = 1'b0;
        step(1);
        en_wr = 1'b0;
        mode = 2'(m); pre = 2'(ps); post = 4'(qs);
        per_wr = 1'b1; per_wd = 15'(per);
        cnt_wr = 1'b1; cnt_wd = '0;
        step(1);
        per_wr = 1'b0; cnt_wr = 1'b0;
    endtask

    task automatic start();
        en_wr = 1'b1; en_wd = 1'b1;
        step(1);
        en_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count after reset", int'(count), 0);
        chk("R1", "en after reset", int'(en), 0);
        chk("R1", "irq after reset", int'(irq), 0);
    endtask

    task automatic t_free();
        setup(0, 3, 0, 0);
        start();
        for (int k = 1; k <= 12; k++) begin
            step(1);
            chk("R3", "free count", int'(count), k % 4);
            chk("R12", "free irq", int'(irq), (k % 4 == 0) ? 1 : 0);
        end
    endtask

    task automatic t_post();
        int n = 0;
        setup(0, 1, 0, 2);
        start();
        for (int k = 1; k <= 24; k++) begin
            step(1);
            if (irq) n++;
            if (k == 6) chk("R7", "first divided pulse at k=6", int'(irq), 1);
        end
        chk("R7", "pulses in 24 cycles at divide 3", n, 4);
    endtask

    task automatic t_prescale();
        for (int s = 0; s < 4; s++) begin
            int div = 1 << (2 * s);
            setup(0, 1000, s, 0);
            start();
            step(div - 1);
            chk("R2", "count before first tick", int'(count), 0);
            step(1);
            chk("R2", "count at first tick", int'(count), 1);
            step(div);
            chk("R2", "count at second tick", int'(count), 2);
        end
    endtask

    task automatic t_oneshot();
        int n = 0;
        setup(1, 2, 0, 5);
        start();
        step(2);
        chk("R4", "oneshot count before match", int'(count), 2);
        step(1);
        chk("R4", "oneshot count after match", int'(count), 0);
        chk("R4", "oneshot enable cleared", int'(en), 0);
        chk("R4", "oneshot pulse ignores postscale", int'(irq), 1);
        for (int k = 0; k < 6; k++) begin
            step(1);
            if (irq) n++;
        end
        chk("R4", "oneshot extra pulses", n, 0);
        chk("R4", "oneshot count stays", int'(count), 0);
    endtask

    task automatic t_updn(bit both);
        setup(both ? 3 : 2, 3, 0, 0);
        start();
        for (int k = 1; k <= 14; k++) begin
            int p = k % 6;
            int ec = (p <= 3) ? p : 6 - p;
            int ed = (p >= 4 || p == 0) ? 1 : 0;
            int ei = ((p == 1 && k > 1) || (both && p == 4)) ? 1 : 0;
            step(1);
            chk("R5", "updn count", int'(count[14:0]), ec);
            chk("R1", "direction flag", int'(count[15]), ed);
            chk(both ? "R6" : "R5", "updn irq", int'(irq), ei);
        end
    endtask

    task automatic t_disable();
        int c;
        int n = 0;
        setup(0, 50, 0, 0);
        start();
        step(5);
        en_wr = 1'b1; en_wd = 1'b0;
        step(1);
        en_wr = 1'b0;
        c = int'(count);
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (irq) n++;
        end
        chk("R8", "count held while off", int'(count), c);
        chk("R8", "no pulses while off", n, 0);
        chk("R8", "enable reads off", int'(en), 0);
    endtask

    task automatic t_zero();
        int n = 0;
        setup(0, 0, 0, 0);
        start();
        for (int k = 0; k < 6; k++) begin
            step(1);
            if (irq) n++;
        end
        chk("R9", "zero period count", int'(count), 0);
        chk("R9", "zero period pulses", n, 0);
        per_wr = 1'b1; per_wd = 15'd5;
        step(1);
        per_wr = 1'b0;
        step(10);
        chk("R10", "period write ignored while locked", int'(count), 0);
        en_wr = 1'b1; en_wd = 1'b0;
        step(1);
        en_wr = 1'b0;
        per_wr = 1'b1; per_wd = 15'd5;
        step(1);
        per_wr = 1'b0;
        start();
        step(3);
        chk("R10", "period accepted after disable", int'(count), 3);
    endtask

    task automatic t_load();
        setup(0, 20, 0, 0);
        start();
        step(3);
        chk("R11", "count before load", int'(count), 3);
        cnt_wr = 1'b1; cnt_wd = 15'd7;
        step(1);
        cnt_wr = 1'b0;
        chk("R11", "loaded value wins over tick", int'(count), 7);
        step(1);
        chk("R11", "counting resumes from load", int'(count), 8);
    endtask

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_free();
        t_post();
        t_prescale();
        t_oneshot();
        t_updn(1'b0);
        t_updn(1'b1);
        t_disable();
        t_zero();
        t_load();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule